// File: doc/BRIEF.md
# Byte-Wide SPI Master with Ordered-Clear Status Flags

This block is a memory-mapped serial peripheral interface master for a simple processor bus. Software writes a byte into a one-entry holding buffer. The block copies that byte into a shift register as soon as the serial engine is free. It then clocks the byte out on the serial clock and data-out lines while it samples the data-in line. An active-low select line can be driven automatically around each byte. Software sets the clock polarity, the clock phase, the bit order and a half-period divider through a control register and a divider register.

Two status flags pace the software. The empty flag shows that the holding buffer may take another byte. It rises when the buffered byte moves into the shifter, so the next byte can be queued while the current one is still on the wire. The complete flag rises when a byte has fully finished, and the received byte becomes readable at that point. The complete flag is cleared only by a status read that sees it set, followed by a read of the data register. Any other order leaves it set, and so does a data write between the two reads. In phase-1 mode the block inserts a guard of at least half a serial-clock period between the empty flag rising (or a byte ending) and the next load of the shift register. A level interrupt output reports either flag when the matching enable bit is set.

Register map (2-bit address): 0 control, 1 divider, 2 status (read-only), 3 data (write queues a byte to transmit; read returns the last received byte).

Top module: `spi_hs_master`

## Requirements
- R1: After reset the status register (address 2) reads 0x02 (empty flag at bit 1 set, complete flag at bit 0 clear). The data register reads 0x00, sel_n is high, sck is low and irq is low.
- R2: With control bit 4 (LSB-first) clear, the byte written to address 3 appears on mosi MSB first. The byte presented on miso MSB first is read back from address 3 once the transfer completes.
- R3: With control bit 4 set, mosi carries bit 0 first and miso is assembled with its first bit in bit 0.
- R4: Control bit 2 sets the idle level of sck. With control bit 3 clear, both sides sample on the first edge of each bit pair. With control bit 3 set, they sample on the second edge. All four combinations move the data bytes correctly.
- R5: A data write accepted while the empty flag is set clears that flag. The flag sets again on the clock after the byte moves into the idle shifter. A data write made while the flag is clear is dropped and never transmitted.
- R6: The complete flag stays clear while a byte is shifting. It sets once all 16 serial-clock edges of the byte have passed, and further status reads alone do not clear it.
- R7: The complete flag clears only when a status read that sees it set is followed by a data read with no data write in between. A data read followed by a status read, or a write of 0xFF to address 2, leaves it set.
- R8: With control bit 3 clear, a queued byte starts one clock after the previous byte ends, so sel_n is high for one cycle between bytes. With control bit 3 set, sel_n stays high for at least divider+1 cycles between queued bytes.
- R9: Successive sck edges within a byte are exactly divider+1 system clocks apart, where the divider is the value at address 1.
- R10: With control bit 5 set, sel_n is low at every sck edge and high again after the byte completes. With bit 5 clear, sel_n stays high throughout.
- R11: irq equals (complete flag AND control bit 6) OR (empty flag AND control bit 7). With both enables clear, irq never asserts, even while the flags change.
- R12: Transfers happen only while control bit 0 (enable) and bit 1 (master) are both set. Otherwise a data write is dropped, the empty flag stays set and sck does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Automatic slave select, active low |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a complete flag that must survive access orders that look like a clear. This covers a data read before the status read, a status read that is cancelled by a data write, and a write of ones to the status register. A bench that simply polls status until the flag rises would never reach these cases. The directed sequence therefore waits a computed number of cycles instead of polling. It then issues the reads and writes one cycle at a time and reads the status back after each step. A similar cycle-exact sequence queues a second and a third byte while the first is still shifting. It measures the select-high gap to show the phase-1 guard and checks that the third byte is dropped.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DIV  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int unsigned STAT_DONE_BIT  = 0;
  localparam int unsigned STAT_EMPTY_BIT = 1;

  // Control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic empty_ie;
    logic done_ie;
    logic ss_auto;
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
  } ctrl_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_SHIFT,
    ENG_TRAIL
  } eng_state_e;

  // Edges are numbered from 0; odd edges are the second of each pair.
  function automatic logic is_sample_edge(input logic cpha, input logic edge_odd);
    return edge_odd == cpha;
  endfunction

  function automatic logic is_shift_edge(input logic cpha, input logic edge_odd,
                                         input logic first_edge, input logic last_edge);
    if (cpha) return !edge_odd && !first_edge;
    else      return edge_odd && !last_edge;
  endfunction

endpackage

// File: rtl/spi_hs_regs.sv
module spi_hs_regs
  import spi_hs_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              empty_flag,
  input  logic              done_flag,
  input  logic [DATA_W-1:0] rx_q,
  output ctrl_t             ctrl,
  output logic [DIV_W-1:0]  div,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_data_ev,
  output logic              rd_data_ev,
  output logic              rd_stat_ev
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic wr_ctrl_ev;
  logic wr_div_ev;

  assign wr_ctrl_ev = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign wr_div_ev  = bus_sel && bus_wr && (bus_addr == REG_DIV);
  assign wr_data_ev = bus_sel && bus_wr && (bus_addr == REG_DATA);
  assign rd_data_ev = bus_sel && !bus_wr && (bus_addr == REG_DATA);
  assign rd_stat_ev = bus_sel && !bus_wr && (bus_addr == REG_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= DIV_W'(DIV_RESET);
    end else begin
      if (wr_ctrl_ev) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_div_ev)  div  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: bus_rdata = DATA_W'(ctrl);
      REG_DIV:  bus_rdata = DATA_W'(div);
      REG_STAT: begin
        bus_rdata[STAT_DONE_BIT]  = done_flag;
        bus_rdata[STAT_EMPTY_BIT] = empty_flag;
      end
      default:  bus_rdata = rx_q;
    endcase
  end

endmodule

// File: rtl/spi_hs_flags.sv
module spi_hs_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr_data_ev,
  input  logic              rd_data_ev,
  input  logic              rd_stat_ev,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_load,
  input  logic              ev_done,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_q,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              armed
);

  logic wr_accept;
  logic done_clear;

  assign wr_accept  = wr_data_ev && go && !buf_full;
  assign done_clear = rd_data_ev && armed;
  assign empty_flag = !buf_full;

  // holding buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
    end else if (wr_accept) begin
      buf_full <= 1'b1;
      buf_q    <= wdata;
    end else if (ev_load) begin
      buf_full <= 1'b0;
    end
  end

  // complete flag: a new completion wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_flag <= 1'b0;
    else if (ev_done)    done_flag <= 1'b1;
    else if (done_clear) done_flag <= 1'b0;
  end

  // clear sequence tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed <= 1'b0;
    else if (wr_data_ev || rd_data_ev) armed <= 1'b0;
    else if (rd_stat_ev && done_flag)  armed <= 1'b1;
  end

endmodule

// File: rtl/spi_hs_engine.sv
module spi_hs_engine
  import spi_hs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              ss_auto,
  input  logic [DIV_W-1:0]  div,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_q,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              ev_load,
  output logic              ev_done,
  output logic              busy,
  output logic              guard_ok,
  output logic [DATA_W-1:0] rx_q
);

  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned ECNT_W = $clog2(EDGES);
  localparam int unsigned GCNT_W = DIV_W + 1;
  localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);
  localparam logic [GCNT_W-1:0] GCNT_MAX  = '1;

  eng_state_e        state;
  logic [DIV_W-1:0]  hcnt;
  logic [ECNT_W-1:0] ecnt;
  logic              phase;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] rx_sh;
  logic [GCNT_W-1:0] gcnt;
  logic              tick;
  logic              edge_now;
  logic              do_sample;
  logic              do_shift;

  function automatic logic [DATA_W-1:0] shift_out(input logic [DATA_W-1:0] v, input logic lsb);
    if (lsb) return {1'b0, v[DATA_W-1:1]};
    else     return {v[DATA_W-2:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] rx_in(input logic [DATA_W-1:0] v, input logic b,
                                              input logic lsb);
    if (lsb) return {b, v[DATA_W-1:1]};
    else     return {v[DATA_W-2:0], b};
  endfunction

  assign tick      = (hcnt == div);
  assign guard_ok  = gcnt > GCNT_W'(div);
  assign busy      = (state != ENG_IDLE);
  assign ev_load   = (state == ENG_IDLE) && go && buf_full && (!cpha || guard_ok);
  assign ev_done   = (state == ENG_TRAIL) && tick && go;
  assign edge_now  = (state == ENG_SHIFT) && tick && go;
  assign do_sample = edge_now && is_sample_edge(cpha, ecnt[0]);
  assign do_shift  = edge_now && is_shift_edge(cpha, ecnt[0], ecnt == '0, ecnt == LAST_EDGE);

  assign sck  = cpol ^ phase;
  assign mosi = lsb_first ? sh[0] : sh[DATA_W-1];
  assign ss_n = !(ss_auto && busy);

  // sequencing of lead, 16 edges and trail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      hcnt  <= '0;
      ecnt  <= '0;
      phase <= 1'b0;
      rx_q  <= '0;
    end else if (!go) begin
      state <= ENG_IDLE;
      hcnt  <= '0;
      phase <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          hcnt <= '0;
          if (ev_load) state <= ENG_LEAD;
        end
        ENG_LEAD: begin
          if (tick) begin
            hcnt  <= '0;
            ecnt  <= '0;
            state <= ENG_SHIFT;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            hcnt  <= '0;
            phase <= ~phase;
            if (ecnt == LAST_EDGE) state <= ENG_TRAIL;
            else                   ecnt  <= ecnt + 1'b1;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            hcnt  <= '0;
            rx_q  <= rx_sh;
            state <= ENG_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (ev_load)  sh <= buf_q;
    else if (do_shift) sh <= shift_out(sh, lsb_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_sh <= '0;
    else if (do_sample) rx_sh <= rx_in(rx_sh, miso, lsb_first);
  end

  // phase-1 guard timer, restarted on every load and every byte end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gcnt <= GCNT_MAX;
    else if (ev_load || ev_done) gcnt <= '0;
    else if (gcnt != GCNT_MAX)   gcnt <= gcnt + 1'b1;
  end

endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_ss_n,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div;
  logic              go;
  logic              wr_data_ev;
  logic              rd_data_ev;
  logic              rd_stat_ev;
  logic              buf_full;
  logic [DATA_W-1:0] buf_q;
  logic              empty_flag;
  logic              done_flag;
  logic              armed;
  logic              ev_load;
  logic              ev_done;
  logic              busy;
  logic              guard_ok;
  logic [DATA_W-1:0] rx_q;

  assign go  = ctrl.enable && ctrl.master;
  assign irq = (done_flag && ctrl.done_ie) || (empty_flag && ctrl.empty_ie);

  spi_hs_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .empty_flag (empty_flag),
    .done_flag  (done_flag),
    .rx_q       (rx_q),
    .ctrl       (ctrl),
    .div        (div),
    .bus_rdata  (bus_rdata),
    .wr_data_ev (wr_data_ev),
    .rd_data_ev (rd_data_ev),
    .rd_stat_ev (rd_stat_ev)
  );

  spi_hs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .wr_data_ev (wr_data_ev),
    .rd_data_ev (rd_data_ev),
    .rd_stat_ev (rd_stat_ev),
    .wdata      (bus_wdata),
    .ev_load    (ev_load),
    .ev_done    (ev_done),
    .buf_full   (buf_full),
    .buf_q      (buf_q),
    .empty_flag (empty_flag),
    .done_flag  (done_flag),
    .armed      (armed)
  );

  spi_hs_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cpol      (ctrl.cpol),
    .cpha      (ctrl.cpha),
    .lsb_first (ctrl.lsb_first),
    .ss_auto   (ctrl.ss_auto),
    .div       (div),
    .buf_full  (buf_full),
    .buf_q     (buf_q),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .ss_n      (spi_ss_n),
    .ev_load   (ev_load),
    .ev_done   (ev_done),
    .busy      (busy),
    .guard_ok  (guard_ok),
    .rx_q      (rx_q)
  );

endmodule

// File: rtl/spi_hs_master_chk.sv
module spi_hs_master_chk (
  input logic clk,
  input logic rst_n,
  input logic done_flag,
  input logic empty_flag,
  input logic rd_data_ev,
  input logic armed,
  input logic ev_load,
  input logic ev_done,
  input logic busy,
  input logic cpol,
  input logic cpha,
  input logic ss_auto,
  input logic sck,
  input logic ss_n,
  input logic irq,
  input logic done_ie,
  input logic empty_ie
);

  // R7: without a data read the complete flag cannot fall
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !rd_data_ev |=> done_flag);

  // R7: a data read that was not preceded by a status read leaves it set
  a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && rd_data_ev && !armed |=> done_flag);

  // R6: end of byte raises the complete flag
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> done_flag);

  // R5: moving the byte into the shifter frees the buffer
  a_r5_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> empty_flag);

  // R4: serial clock rests at the polarity level while idle
  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  // R8: phase-1 mode never reloads in the clock right after a byte ends
  a_r8_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && cpha |=> !ev_load);

  // R10: every serial-clock edge falls inside an active select
  a_r10_edge_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    ss_auto && busy && (sck != $past(sck)) && (cpol == $past(cpol)) |-> !ss_n);

  // R11: interrupt stays low with both enables cleared
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ie && !empty_ie |-> !irq);

endmodule

bind spi_hs_master spi_hs_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_flag  (done_flag),
  .empty_flag (empty_flag),
  .rd_data_ev (rd_data_ev),
  .armed      (armed),
  .ev_load    (ev_load),
  .ev_done    (ev_done),
  .busy       (busy),
  .cpol       (ctrl.cpol),
  .cpha       (ctrl.cpha),
  .ss_auto    (ctrl.ss_auto),
  .sck        (spi_sck),
  .ss_n       (spi_ss_n),
  .irq        (irq),
  .done_ie    (ctrl.done_ie),
  .empty_ie   (ctrl.empty_ie)
);

// File: tb/spi_hs_master_tb.sv
module spi_hs_master_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_mosi, spi_ss_n, irq;
  logic       spi_miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hs_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench-side view of the mode
  logic tb_cpha = 0, tb_lsb = 0, tb_ssauto = 0;
  int   tb_div = 3;
  logic mon_en = 0;

  // slave model and monitor state
  logic [7:0] slave_b [64];
  logic [7:0] mon_tx [64];
  int  nb = 0, ecnt = 0, scnt = 0, cyc = 0, last_edge = 0;
  int  per_err = 0, ss_err = 0, edge_total = 0;
  int  rise_cyc = 0, last_gap = 0;
  logic [7:0] seq = 0;
  logic prev_sck = 0, prev_ss = 1, irq_seen = 0;

  function automatic logic [7:0] bitrev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_wire_order(input logic [7:0] v, input logic lsb);
    return lsb ? bitrev(v) : v;
  endfunction

  function automatic logic slave_bit(input logic [7:0] v, input int j, input logic lsb);
    if (j > 7) return 1'b0;
    return lsb ? v[j] : v[7-j];
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (irq) irq_seen = 1;
    if (spi_ss_n && !prev_ss) rise_cyc = cyc;
    if (!spi_ss_n && prev_ss) last_gap = cyc - rise_cyc;
    prev_ss = spi_ss_n;
    if (!mon_en) begin
      ecnt = 0; scnt = 0; seq = 0; prev_sck = spi_sck;
    end else if (spi_sck !== prev_sck) begin
      prev_sck = spi_sck;
      edge_total = edge_total + 1;
      if (ecnt > 0 && (cyc - last_edge) != tb_div + 1) per_err = per_err + 1;
      last_edge = cyc;
      if (tb_ssauto ? (spi_ss_n !== 1'b0) : (spi_ss_n !== 1'b1)) ss_err = ss_err + 1;
      if ((ecnt % 2) == int'(tb_cpha)) begin
        seq = {seq[6:0], spi_mosi};
        scnt = scnt + 1;
      end
      ecnt = ecnt + 1;
      if (ecnt == 16) begin
        mon_tx[nb] = seq;
        nb = (nb + 1) % 64;
        ecnt = 0; scnt = 0;
      end
    end
    spi_miso = slave_bit(slave_b[nb], scnt, tb_lsb);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bus tasks: called at a falling edge, return at the next one
  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] ctrl, input int dv);
    mon_en = 0;
    bwr(2'd0, ctrl);
    bwr(2'd1, dv[7:0]);
    tb_div = dv; tb_cpha = ctrl[3]; tb_lsb = ctrl[4]; tb_ssauto = ctrl[5];
    idle(2);
    mon_en = 1;
    idle(1);
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 0;
    for (int i = 0; i < 3000; i++) begin
      brd(2'd2, st);
      if (st[0]) break;
    end
  endtask

  task automatic wait_bytes(input int target);
    for (int i = 0; i < 3000; i++) begin
      if (nb == target) break;
      idle(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd, st, tx, txa, txb, ctrl;
    int base, dv;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) slave_b[i] = 8'($urandom);

    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    brd(2'd2, rd); chk(rd == 8'h02, "R1", "status", rd, 8'h02);
    brd(2'd3, rd); chk(rd == 8'h00, "R1", "data", rd, 8'h00);
    chk(spi_ss_n == 1'b1, "R1", "sel_n", spi_ss_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck", spi_sck, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);

    // random modes: R2 R3 R4 R9 R10
    for (int it = 0; it < 16; it++) begin
      ctrl = 8'h03;
      ctrl[2] = 1'($urandom); ctrl[3] = 1'($urandom);
      ctrl[4] = 1'($urandom); ctrl[5] = 1'($urandom);
      dv = int'($urandom % 4);
      setup(ctrl, dv);
      chk(spi_sck == ctrl[2], "R4", "idle sck", spi_sck, ctrl[2]);
      per_err = 0; ss_err = 0;
      base = nb;
      tx = 8'($urandom);
      bwr(2'd3, tx);
      wait_done(st);
      chk(st[0] == 1'b1, "R6", "complete seen", st, 8'h03);
      chk(mon_tx[base] == exp_wire_order(tx, ctrl[4]), ctrl[4] ? "R3" : "R2",
          "mosi order", mon_tx[base], exp_wire_order(tx, ctrl[4]));
      brd(2'd3, rd);
      chk(rd == slave_b[base], ctrl[3] ? "R4 phase1" : "R4 phase0", "rx byte",
          rd, slave_b[base]);
      brd(2'd2, st);
      chk(st == 8'h02, "R7", "cleared by status+data", st, 8'h02);
      chk(per_err == 0, "R9", "half period", per_err, 0);
      chk(ss_err == 0, "R10", "select at edges", ss_err, 0);
      chk(spi_ss_n == 1'b1, "R10", "select after byte", spi_ss_n, 1);
    end

    // R6 R7 ordered clear
    setup(8'h23, 1);
    base = nb;
    bwr(2'd3, 8'hC3);
    idle(3);
    brd(2'd2, st); chk(st == 8'h02, "R6", "clear mid-byte", st, 8'h02);
    idle(60);
    brd(2'd3, rd); chk(rd == slave_b[base], "R2", "rx A", rd, slave_b[base]);
    brd(2'd2, st); chk(st == 8'h03, "R7", "data then status keeps", st, 8'h03);
    brd(2'd2, st); chk(st == 8'h03, "R6", "status alone keeps", st, 8'h03);
    bwr(2'd3, 8'h3C);
    brd(2'd3, rd);
    brd(2'd2, st); chk(st[0] == 1'b1, "R7", "write between disarms", st, 8'h03);
    bwr(2'd2, 8'hFF);
    brd(2'd2, st); chk(st[0] == 1'b1, "R7", "ones to status", st, 8'h03);
    idle(60);
    chk(mon_tx[base+1] == 8'h3C, "R2", "mosi B", mon_tx[base+1], 8'h3C);
    brd(2'd3, rd); chk(rd == slave_b[base+1], "R2", "rx B", rd, slave_b[base+1]);
    brd(2'd2, st); chk(st == 8'h02, "R7", "cleared after armed read", st, 8'h02);

    // R5 R8 queued bytes, phase 0 then phase 1
    for (int ph = 0; ph < 2; ph++) begin
      ctrl = 8'h23; ctrl[3] = 1'(ph);
      setup(ctrl, 2);
      base = nb;
      txa = 8'($urandom); txb = 8'($urandom);
      bwr(2'd3, txa);
      brd(2'd2, st); chk(st == 8'h00, "R5", "empty cleared by write", st, 8'h00);
      brd(2'd2, st); chk(st == 8'h02, "R5", "empty set on load", st, 8'h02);
      bwr(2'd3, txb);
      bwr(2'd3, 8'hA5);
      brd(2'd2, st); chk(st == 8'h00, "R5", "buffer held", st, 8'h00);
      wait_bytes((base + 2) % 64);
      idle(150);
      chk(nb == (base + 2) % 64, "R5", "third write dropped", nb - base, 2);
      chk(mon_tx[base] == txa, "R5", "first byte", mon_tx[base], txa);
      chk(mon_tx[(base+1)%64] == txb, "R5", "second byte", mon_tx[(base+1)%64], txb);
      if (ph == 0) chk(last_gap == 1, "R8", "phase0 gap", last_gap, 1);
      else         chk(last_gap >= 3, "R8", "phase1 gap", last_gap, 3);
      brd(2'd2, st);
      brd(2'd3, rd);
      chk(rd == slave_b[(base+1)%64], "R4", "rx last", rd, slave_b[(base+1)%64]);
    end

    // R11 interrupt
    setup(8'h83, 1);
    chk(irq == 1'b1, "R11", "empty irq", irq, 1);
    setup(8'h43, 1);
    chk(irq == 1'b0, "R11", "no empty irq", irq, 0);
    bwr(2'd3, 8'h81);
    idle(4);
    chk(irq == 1'b0, "R11", "busy irq", irq, 0);
    idle(60);
    chk(irq == 1'b1, "R11", "complete irq", irq, 1);
    brd(2'd2, st); brd(2'd3, rd);
    chk(irq == 1'b0, "R11", "irq after clear", irq, 0);
    setup(8'h03, 1);
    irq_seen = 0;
    bwr(2'd3, 8'h18);
    idle(60);
    chk(irq_seen == 1'b0, "R11", "masked irq", irq_seen, 0);
    brd(2'd2, st); brd(2'd3, rd);

    // R12 disabled or not master
    for (int k = 0; k < 2; k++) begin
      setup(k == 0 ? 8'h01 : 8'h02, 1);
      base = edge_total;
      bwr(2'd3, 8'h5A);
      idle(60);
      brd(2'd2, st); chk(st == 8'h02, "R12", "write dropped", st, 8'h02);
      chk(edge_total == base, "R12", "no sck edges", edge_total - base, 0);
    end

    // R10 select held high when automatic select off
    setup(8'h03, 0);
    ss_err = 0;
    base = nb;
    bwr(2'd3, 8'h96);
    wait_done(st);
    brd(2'd3, rd);
    chk(ss_err == 0, "R10", "select stays high", ss_err, 0);
    chk(mon_tx[base] == 8'h96, "R2", "byte without select", mon_tx[base], 8'h96);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule